// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block holds a row of single-bit storage cells, 2^SEL_W of them (eight by default), and drives one output per cell. A binary address picks one cell, and a single data input supplies the value. Two active-low controls, a clear line and an enable line, together select one of four operating modes. The block can write one addressed bit, hold every bit, act as a one-hot demultiplexer of the data input, or clear everything.

Storage is sampled on the rising clock edge, and the mode decode is explicit. The demultiplex and clear modes override the outputs combinationally, without waiting for a clock edge. Demultiplex mode leaves the stored bits alone, so the previous contents show again once the block leaves that mode. Clear mode zeroes the storage at the next edge.

The address may only be changed while the block is in hold mode. A multi-bit address change during a write could briefly select the wrong cell. Users therefore step an address as hold, then set the address, then write.

Top module: `addr_latch_demux`

## Requirements
- R1: The mode is decoded from the controls as {clr_n, en_n}. 2'b10 is write, 2'b11 is hold, 2'b00 is demultiplex and 2'b01 is clear. Every mode can be entered from every other mode.
- R2: In write mode, the rising edge loads din into the cell whose index equals sel. Every other cell keeps its value. The new value shows on q after that edge.
- R3: In hold mode, q shows the stored bits, and changes on sel and din have no effect on q or on the storage.
- R4: In demultiplex mode, q[sel] equals din and every other bit of q is 0. This follows the inputs combinationally, within the same cycle.
- R5: Demultiplex mode does not change the storage. On return to write or hold mode, q shows the bits stored before demultiplex mode was entered.
- R6: In clear mode, every bit of q is 0 at once, whatever sel and din are.
- R7: Clear mode zeroes the storage at the rising edge, so q reads all zeros after returning to hold mode.
- R8: The synchronous active-low rst_n zeroes the storage at the rising edge, so q is all zeros after reset.
- R9: Output bit i is the cell selected by the binary value i on sel (sel = 0 selects q[0], and sel = 2^SEL_W-1 selects the top bit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the storage |
| rst_n | input | 1 | Synchronous active-low reset of the storage |
| clr_n | input | 1 | Active-low clear control, one half of the mode select |
| en_n | input | 1 | Active-low enable control, the other half of the mode select |
| sel | input | SEL_W | Binary address of the cell or output |
| din | input | 1 | Data input |
| q | output | 2^SEL_W | Stored bits, or the demultiplexed or cleared view |

## Verification
The hardest case to reach is showing that demultiplex mode leaves the storage intact. During that mode the outputs hide the storage completely, so the stored bits can only be seen after the block leaves it. The bench first fills the cells with a known irregular pattern, then sweeps every address and data value in demultiplex mode, and then switches to hold mode and compares q with that pattern. Mode transitions are covered by walking all sixteen ordered mode pairs, each from a fresh hold step that sets the address, so the address is never changed during a write.

// File: rtl/alx_pkg.sv
// Package: shared mode type and the mode decode for the addressable latch.
// Assumes the controls are active-low and already synchronous to clk.
package alx_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } alx_mode_e;

    // Map {clr_n, en_n} onto the operating mode.
    function automatic alx_mode_e decode_mode(input logic clr_n, input logic en_n);
        alx_mode_e m;
        case ({clr_n, en_n})
            2'b10:   m = MODE_WRITE;
            2'b11:   m = MODE_HOLD;
            2'b00:   m = MODE_DEMUX;
            default: m = MODE_CLEAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alx_mode_dec.sv
// Mode decoder: turns the two active-low controls into one mode value.
// Assumes nothing beyond stable inputs; purely combinational.
module alx_mode_dec
    import alx_pkg::*;
(
    input  logic      clr_n,
    input  logic      en_n,
    output alx_mode_e mode
);

    // Combinational decode of the control pair.
    always_comb begin
        mode = decode_mode(clr_n, en_n);
    end

endmodule

// File: rtl/alx_addr_dec.sv
// Address decoder: binary select to one-hot cell select.
// Assumes sel is binary; exactly one output bit is set for each value.
module alx_addr_dec #(
    parameter int SEL_W = 3,
    localparam int NUM_OUT = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_OUT-1:0] onehot
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_cmp
        // Compare the address against the index of this cell.
        always_comb begin
            onehot[i] = (sel == SEL_W'(i));
        end
    end

endmodule

// File: rtl/alx_bit_store.sv
// Storage row: one flop per cell with per-cell write enable.
// Assumes rst_n is synchronous and active-low; the clear mode zeroes every cell
// and the write mode loads din into the one-hot selected cell.
module alx_bit_store
    import alx_pkg::*;
#(
    parameter int NUM_OUT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  alx_mode_e          mode,
    input  logic [NUM_OUT-1:0] onehot,
    input  logic               din,
    output logic [NUM_OUT-1:0] store
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
        // Update one cell: reset, clear, addressed write, else keep.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store[i] <= 1'b0;
            end else if (mode == MODE_CLEAR) begin
                store[i] <= 1'b0;
            end else if (mode == MODE_WRITE && onehot[i]) begin
                store[i] <= din;
            end
        end
    end

endmodule

// File: rtl/alx_out_sel.sv
// Output selector: per bit, picks stored value, demultiplexed data or zero.
// Assumes onehot has at most one bit set; combinational.
module alx_out_sel
    import alx_pkg::*;
#(
    parameter int NUM_OUT = 8
) (
    input  alx_mode_e          mode,
    input  logic [NUM_OUT-1:0] store,
    input  logic [NUM_OUT-1:0] onehot,
    input  logic               din,
    output logic [NUM_OUT-1:0] q
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
        // Choose the source of this output bit from the mode.
        always_comb begin
            case (mode)
                MODE_DEMUX: q[i] = onehot[i] & din;
                MODE_CLEAR: q[i] = 1'b0;
                default:    q[i] = store[i];
            endcase
        end
    end

endmodule

// File: rtl/addr_latch_demux.sv
// Top: addressable bit latch with hold, demultiplex and clear modes.
// Assumes the address only changes in hold mode while writing is in use;
// storage is sampled on the rising edge, the demux and clear views are combinational.
module addr_latch_demux #(
    parameter int SEL_W = 3,
    localparam int NUM_OUT = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_n,
    input  logic               en_n,
    input  logic [SEL_W-1:0]   sel,
    input  logic               din,
    output logic [NUM_OUT-1:0] q
);

    alx_pkg::alx_mode_e  mode;
    logic [NUM_OUT-1:0]  onehot;
    logic [NUM_OUT-1:0]  store;

    alx_mode_dec u_mode (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode)
    );

    alx_addr_dec #(.SEL_W(SEL_W)) u_addr (
        .sel    (sel),
        .onehot (onehot)
    );

    alx_bit_store #(.NUM_OUT(NUM_OUT)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .onehot (onehot),
        .din    (din),
        .store  (store)
    );

    alx_out_sel #(.NUM_OUT(NUM_OUT)) u_out (
        .mode   (mode),
        .store  (store),
        .onehot (onehot),
        .din    (din),
        .q      (q)
    );

endmodule

// File: rtl/alx_checker.sv
// Checker: port-level properties of the addressable latch, bound to the top.
module alx_checker #(
    parameter int SEL_W = 3,
    localparam int NUM_OUT = 1 << SEL_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_n,
    input logic               en_n,
    input logic [SEL_W-1:0]   sel,
    input logic               din,
    input logic [NUM_OUT-1:0] q
);

    localparam logic [NUM_OUT-1:0] ONE = NUM_OUT'(1);

    // R2, R9: after a write edge the addressed output carries the written data.
    a_r2_addressed_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !en_n) |=> (!clr_n || (q[$past(sel)] == $past(din))));

    // R2: a write leaves every non-addressed output unchanged.
    a_r2_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !en_n) |=> (!clr_n || (((q ^ $past(q)) & ~(ONE << $past(sel))) == '0)));

    // R3: consecutive hold cycles keep q stable.
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && en_n && $past(clr_n && en_n) && $past(rst_n)) |-> $stable(q));

    // R4: demultiplex mode shows at most one high bit, present only when din is high.
    a_r4_demux_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !en_n) |-> ($onehot0(q) && ((q != '0) == din)));

    // R6: clear mode forces all outputs low.
    a_r6_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && en_n) |-> (q == '0));

    // R7: a clear edge leaves zeroed storage visible in write or hold mode.
    a_r7_clear_storage: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!clr_n && en_n) && clr_n) |-> (q == '0));

endmodule

bind addr_latch_demux alx_checker #(.SEL_W(SEL_W)) u_alx_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (clr_n),
    .en_n  (en_n),
    .sel   (sel),
    .din   (din),
    .q     (q)
);

// File: tb/test_addr_latch_demux.sv
module test_addr_latch_demux;

    localparam int SEL_W = 3;
    localparam int NOUT  = 1 << SEL_W;
    localparam time TCK  = 8ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr_n = 1'b1;
    logic             en_n = 1'b1;
    logic [SEL_W-1:0] sel = '0;
    logic             din = 1'b0;
    logic [NOUT-1:0]  q;

    logic [NOUT-1:0]  model = '0;
    int n_vec = 0;
    int n_bad = 0;

    addr_latch_demux #(.SEL_W(SEL_W)) i_addr_latch_demux (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .en_n(en_n),
        .sel(sel), .din(din), .q(q)
    );

    always #(TCK/2) clk = ~clk;

    task automatic check(input string tag, input logic [NOUT-1:0] act, input logic [NOUT-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one vector at the falling edge, check q, then advance the model at the rising edge.
    task automatic apply(input logic c, input logic e, input logic [SEL_W-1:0] s,
                         input logic d, input string tag);
        logic [NOUT-1:0] exp;
        @(negedge clk);
        clr_n = c; en_n = e; sel = s; din = d;
        #1;
        case ({c, e})
            2'b00:   exp = NOUT'(d) << s;
            2'b01:   exp = '0;
            default: exp = model;
        endcase
        check(tag, q, exp);
        @(posedge clk);
        if ({c, e} == 2'b10) model[s] = d;
        if ({c, e} == 2'b01) model = '0;
    endtask

    // Fill storage with a pattern, stepping the address only in hold mode.
    task automatic fill(input logic [NOUT-1:0] pat, input string tag);
        for (int i = 0; i < NOUT; i++) begin
            apply(1'b1, 1'b1, SEL_W'(i), ~pat[i], tag);
            apply(1'b1, 1'b0, SEL_W'(i), pat[i], tag);
        end
        apply(1'b1, 1'b1, '0, 1'b0, tag);
    endtask

    initial begin
        #(TCK * 200000);
        n_bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [NOUT-1:0] pats [4];
        pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h00;

        // R8: synchronous reset zeroes storage.
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        check("R8 reset state", q, '0);
        model = '0;

        // R2, R9: addressed writes of several patterns, checked in hold mode.
        for (int p = 0; p < 4; p++) begin
            fill(pats[p], "R2 write sweep");
            @(negedge clk); #1;
            check("R9 pattern readback", q, pats[p]);
        end

        // R3: hold ignores every sel and din value.
        fill(8'h96, "R2 write setup");
        for (int s = 0; s < NOUT; s++)
            for (int d = 0; d < 2; d++)
                apply(1'b1, 1'b1, SEL_W'(s), 1'(d), "R3 hold ignores inputs");

        // R4, R9: demultiplex sweep, then R5 storage returns.
        for (int s = 0; s < NOUT; s++)
            for (int d = 0; d < 2; d++)
                apply(1'b0, 1'b0, SEL_W'(s), 1'(d), "R4 demux output");
        apply(1'b1, 1'b1, 3'd5, 1'b1, "R5 storage after demux");
        @(negedge clk); #1;
        check("R5 stored pattern intact", q, 8'h96);

        // R6: clear overrides, R7: storage zero afterwards.
        for (int s = 0; s < NOUT; s++)
            for (int d = 0; d < 2; d++)
                apply(1'b0, 1'b1, SEL_W'(s), 1'(d), "R6 clear output");
        apply(1'b1, 1'b1, 3'd2, 1'b1, "R7 storage after clear");
        @(negedge clk); #1;
        check("R7 zero storage", q, '0);

        // R1: all ordered mode pairs from a known pattern.
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                logic [SEL_W-1:0] k;
                k = SEL_W'(a * 4 + b);
                fill(8'h5A ^ NOUT'(a * 4 + b), "R1 transition setup");
                apply(1'b1, 1'b1, k, 1'b0, "R1 transition hold");
                apply(1'(a >> 1), 1'(a & 1), k, ~model[k], "R1 transition first");
                apply(1'(b >> 1), 1'(b & 1), k, 1'(b ^ a) ^ model[k], "R1 transition second");
                apply(1'b1, 1'b1, k, 1'b1, "R1 transition settle");
            end

        // R8: reset during a write zeroes storage.
        fill(8'hE7, "R8 setup");
        @(negedge clk);
        rst_n = 1'b0; clr_n = 1'b1; en_n = 1'b0; sel = 3'd3; din = 1'b1;
        @(posedge clk);
        @(negedge clk);
        en_n = 1'b1; #1;
        check("R8 reset clears storage", q, '0);
        rst_n = 1'b1;
        model = '0;
        apply(1'b1, 1'b1, 3'd0, 1'b0, "R8 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule